// File: doc/BRIEF.md
# PLL Digital Lock Detector

This block reports whether a phase-locked loop has settled. It watches the up and down outputs of a phase-frequency detector and samples them with a fast clock. On each comparison cycle it counts how many sampling periods the error pulse lasts. The error pulse is the low phase of the NOR of up and down. The count therefore always includes the detector's anti-backlash pulse on top of the true phase error.

Lock is declared only after a run of consecutive small-error cycles. A precision bit sets the run length to 3 or 5 cycles. Once lock is held, it is dropped by a single cycle whose error is larger than a second, wider threshold. Errors between the two thresholds neither build lock nor break it. Both thresholds are inputs given in sampling-clock periods, and the lock threshold must not exceed the loss threshold. The up and down inputs are asynchronous to the sampling clock and are synchronized inside the block.

Top module: `pll_lock_monitor`

## Requirements
- R1: A synchronous reset drives lockFlag to 0 and clears the count of consecutive good cycles, so good cycles seen before reset do not count toward lock afterwards.
- R2: The error width of a cycle is the number of sampling-clock periods in which upPulse OR downPulse is high. Either input alone produces an error pulse. When both are high, the width is that of their union. A comparison cycle ends when both inputs have returned low.
- R3: With precisionSel = 0, lockFlag rises after 3 consecutive cycles whose width is less than or equal to lockThresh, and not after 2.
- R4: With precisionSel = 1, lockFlag rises after 5 consecutive such cycles, and not after 4.
- R5: While unlocked, a cycle whose width exceeds lockThresh restarts the consecutive count from zero.
- R6: While locked, a cycle whose width is greater than lockThresh but not greater than lossThresh leaves lockFlag high.
- R7: While locked, a single cycle whose width exceeds lossThresh clears lockFlag.
- R8: The width count saturates at 2^CNT_W - 1 and never wraps. With the default CNT_W = 8, a 300-period pulse counts as 255.
- R9: lockFlag changes only on the decision that follows the end of a comparison cycle, two sampling clocks after the end is detected. It never changes while an error pulse is still in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| upPulse | input | 1 | Up output of the phase detector (asynchronous) |
| downPulse | input | 1 | Down output of the phase detector (asynchronous) |
| precisionSel | input | 1 | 0: lock needs a run of 3 good cycles, 1: a run of 5 |
| lockThresh | input | CNT_W | Largest width, in sampling periods, accepted as in-window |
| lossThresh | input | CNT_W | Widths above this value clear lock |
| lockFlag | output | 1 | 1 = locked, 0 = unlocked |

## Verification
The bench places widths exactly on each threshold, because an off-by-one comparison would make a design lock on a width of lockThresh + 1 or drop lock on a width equal to lossThresh. It places a bad cycle in the middle of a good run and resets in the middle of a run. A design that does not clear its run count would then lock one or more cycles early. It drives down-only pulses and overlapping up/down pulses, which would catch a design that measures only one detector output. Finally it sends a 300-period pulse against loss thresholds of 254 and 255. A wrapping counter would read this pulse as 44 and keep lock. The bench also checks that the flag holds steady in the middle of that pulse, which would expose a design that decides before the cycle ends.

// File: rtl/lockmon_pkg.sv
package lockmon_pkg;
  // Per-cycle verdict handed from the datapath to the control.
  typedef struct packed {
    logic cycleDone;  // one-clock strobe: a comparison cycle has ended
    logic inWindow;   // width <= lock threshold
    logic overLoss;   // width >  loss threshold
  } verdict_t;
endpackage

// File: rtl/lockmon_sync.sv
module lockmon_sync #(
  parameter int N      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [STAGES-1:0][N-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe <= '0;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) begin
        pipe[i] <= pipe[i-1];
      end
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/lockmon_datapath.sv
module lockmon_datapath
  import lockmon_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upPulse,
  input  logic             downPulse,
  input  logic [CNT_W-1:0] lockThresh,
  input  logic [CNT_W-1:0] lossThresh,
  output verdict_t         verdict
);
  localparam logic [CNT_W-1:0] WIDTH_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] WIDTH_ONE = CNT_W'(1);

  logic [1:0]       syncQ;
  logic             errLow;
  logic             prevLow;
  logic             endEvt;
  logic [CNT_W-1:0] widthCnt;
  logic [CNT_W-1:0] widthNext;

  lockmon_sync #(.N(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({upPulse, downPulse}),
    .q   (syncQ)
  );

  // Error pulse is the low phase of NOR(up, down).
  assign errLow = |syncQ;
  assign endEvt = prevLow && !errLow;

  always_comb begin
    if (!prevLow)                widthNext = WIDTH_ONE;
    else if (widthCnt == WIDTH_MAX) widthNext = widthCnt;
    else                         widthNext = widthCnt + WIDTH_ONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prevLow  <= 1'b0;
      widthCnt <= '0;
    end else begin
      prevLow <= errLow;
      if (errLow) widthCnt <= widthNext;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      verdict <= '0;
    end else begin
      verdict.cycleDone <= endEvt;
      verdict.inWindow  <= endEvt && (widthCnt <= lockThresh);
      verdict.overLoss  <= endEvt && (widthCnt >  lossThresh);
    end
  end

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (errLow && prevLow) |=> (widthCnt >= $past(widthCnt))) else $error("width wrapped"); // R8

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    verdict.cycleDone |=> !verdict.cycleDone) else $error("double strobe"); // R2
endmodule

// File: rtl/lockmon_control.sv
module lockmon_control
  import lockmon_pkg::*;
#(
  parameter int RUN_SHORT = 3,
  parameter int RUN_LONG  = 5
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     precisionSel,
  input  verdict_t verdict,
  output logic     lockFlag
);
  localparam int RUN_W = $clog2(RUN_LONG + 1);

  logic [RUN_W-1:0] runCnt;
  logic [RUN_W-1:0] runNext;
  logic [RUN_W-1:0] target;

  assign target  = precisionSel ? RUN_W'(RUN_LONG) : RUN_W'(RUN_SHORT);
  assign runNext = runCnt + RUN_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      lockFlag <= 1'b0;
      runCnt   <= '0;
    end else if (verdict.cycleDone) begin
      if (!lockFlag) begin
        if (verdict.inWindow) begin
          if (runNext >= target) begin
            lockFlag <= 1'b1;
            runCnt   <= '0;
          end else begin
            runCnt <= runNext;
          end
        end else begin
          runCnt <= '0;
        end
      end else if (verdict.overLoss) begin
        lockFlag <= 1'b0;
        runCnt   <= '0;
      end
    end
  end

  AST_FLAG_ON_DECISION: assert property (@(posedge clk) disable iff (rst)
    !$stable(lockFlag) |-> $past(verdict.cycleDone)) else $error("flag moved off decision"); // R9

  AST_LOSS_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (lockFlag && verdict.cycleDone && verdict.overLoss) |=> !lockFlag) else $error("loss kept lock"); // R7

  AST_MID_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (lockFlag && verdict.cycleDone && !verdict.overLoss) |=> lockFlag) else $error("lock lost early"); // R6

  AST_BAD_RESTARTS: assert property (@(posedge clk) disable iff (rst)
    (!lockFlag && verdict.cycleDone && !verdict.inWindow) |=> (runCnt == '0)) else $error("run kept"); // R5

  AST_RUN_BOUND: assert property (@(posedge clk) disable iff (rst)
    runCnt < RUN_W'(RUN_LONG)) else $error("run overflow"); // R4
endmodule

// File: rtl/pll_lock_monitor.sv
module pll_lock_monitor
  import lockmon_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int RUN_SHORT   = 3,
  parameter int RUN_LONG    = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upPulse,
  input  logic             downPulse,
  input  logic             precisionSel,
  input  logic [CNT_W-1:0] lockThresh,
  input  logic [CNT_W-1:0] lossThresh,
  output logic             lockFlag
);
  verdict_t verdict;

  lockmon_datapath #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_datapath (
    .clk        (clk),
    .rst        (rst),
    .upPulse    (upPulse),
    .downPulse  (downPulse),
    .lockThresh (lockThresh),
    .lossThresh (lossThresh),
    .verdict    (verdict)
  );

  lockmon_control #(.RUN_SHORT(RUN_SHORT), .RUN_LONG(RUN_LONG)) u_control (
    .clk          (clk),
    .rst          (rst),
    .precisionSel (precisionSel),
    .verdict      (verdict),
    .lockFlag     (lockFlag)
  );

  AST_RESET_UNLOCKED: assert property (@(posedge clk)
    $past(rst) |-> !lockFlag) else $error("not unlocked after reset"); // R1
endmodule

// File: tb/pll_lock_monitor_bench.sv
module pll_lock_monitor_bench;
  localparam int CNT_W = 8;
  localparam int GAP   = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             upPulse = 1'b0;
  logic             downPulse = 1'b0;
  logic             precisionSel = 1'b0;
  logic [CNT_W-1:0] lockThresh = 8'd15;
  logic [CNT_W-1:0] lossThresh = 8'd30;
  logic             lockFlag;

  int nChecks = 0;
  int nFail   = 0;
  bit finished = 1'b0;

  pll_lock_monitor #(.CNT_W(CNT_W)) u_pll_lock_monitor (
    .clk          (clk),
    .rst          (rst),
    .upPulse      (upPulse),
    .downPulse    (downPulse),
    .precisionSel (precisionSel),
    .lockThresh   (lockThresh),
    .lossThresh   (lossThresh),
    .lockFlag     (lockFlag)
  );

  always #4 clk = ~clk;

  task automatic check(input logic act, input logic exp, input string tag);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: lockFlag=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // One comparison cycle: up high for upW samples, down for dnW, starting together.
  task automatic pulse(input int upW, input int dnW);
    int span;
    span = (upW > dnW) ? upW : dnW;
    @(negedge clk);
    upPulse   = (upW > 0);
    downPulse = (dnW > 0);
    for (int k = 1; k <= span; k++) begin
      @(negedge clk);
      if (k >= upW) upPulse = 1'b0;
      if (k >= dnW) downPulse = 1'b0;
    end
    repeat (GAP) @(negedge clk);
  endtask

  task automatic goodRun(input int n, input int w);
    for (int i = 0; i < n; i++) pulse(w, 0);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic testReset();
    doReset();
    check(lockFlag, 1'b0, "R1 unlocked after reset");
  endtask

  task automatic testShortRun();
    precisionSel = 1'b0;
    goodRun(2, 5);
    check(lockFlag, 1'b0, "R3 no lock after 2");
    goodRun(1, 5);
    check(lockFlag, 1'b1, "R3 lock after 3");
  endtask

  task automatic testHysteresis();
    pulse(20, 0);
    check(lockFlag, 1'b1, "R6 mid error keeps lock");
    pulse(30, 0);
    check(lockFlag, 1'b1, "R6 width equal loss keeps lock");
    pulse(31, 0);
    check(lockFlag, 1'b0, "R7 width over loss clears");
  endtask

  task automatic testRestart();
    goodRun(2, 5);
    pulse(16, 0);
    goodRun(2, 5);
    check(lockFlag, 1'b0, "R5 bad cycle restarts run");
    goodRun(1, 15);
    check(lockFlag, 1'b1, "R3 width equal lockThresh is in window");
  endtask

  task automatic testLongRun();
    pulse(40, 0);
    check(lockFlag, 1'b0, "R7 unlock before long run");
    precisionSel = 1'b1;
    goodRun(4, 5);
    check(lockFlag, 1'b0, "R4 no lock after 4");
    goodRun(1, 5);
    check(lockFlag, 1'b1, "R4 lock after 5");
    precisionSel = 1'b0;
  endtask

  task automatic testBothInputs();
    pulse(40, 0);
    for (int i = 0; i < 3; i++) pulse(0, 5);
    check(lockFlag, 1'b1, "R2 down-only pulses lock");
    pulse(3, 40);
    check(lockFlag, 1'b0, "R2 union of up and down measured");
  endtask

  task automatic testSaturation();
    lossThresh = 8'd255;
    goodRun(3, 5);
    check(lockFlag, 1'b1, "R8 locked before long pulse");
    @(negedge clk);
    upPulse = 1'b1;
    repeat (150) @(negedge clk);
    check(lockFlag, 1'b1, "R9 flag steady mid pulse");
    repeat (150) @(negedge clk);
    upPulse = 1'b0;
    repeat (GAP) @(negedge clk);
    check(lockFlag, 1'b1, "R8 saturated width not over 255");
    lossThresh = 8'd254;
    pulse(300, 0);
    check(lockFlag, 1'b0, "R8 saturated width over 254");
    lossThresh = 8'd30;
  endtask

  task automatic testResetMidRun();
    goodRun(2, 5);
    doReset();
    check(lockFlag, 1'b0, "R1 reset mid run");
    goodRun(1, 5);
    check(lockFlag, 1'b0, "R1 run cleared by reset");
    goodRun(2, 5);
    check(lockFlag, 1'b1, "R1 fresh run locks");
    doReset();
    check(lockFlag, 1'b0, "R1 reset clears lock");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    testReset();
    testShortRun();
    testHysteresis();
    testRestart();
    testLongRun();
    testBothInputs();
    testSaturation();
    testResetMidRun();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end
endmodule